// File: doc/BRIEF.md
# Nixie Digit Crossfade and Cathode Exerciser

This block drives the one-of-ten cathode driver of a single nixie tube. On every clock it decides which numeral is lit, and it gives that numeral both as a BCD code and as a one-hot cathode select. When it is idle it shows the requested digit. When the request changes, it moves to the new digit in one of three ways chosen by a mode input: it swaps at once, it crossfades, or it rolls through the numerals in between like a slot machine. A crossfade time-slices a single selected cathode between the old and the new numeral. The share of each PWM period given to the new numeral rises in sixteen equal steps.

A start pulse runs an anti-poisoning sweep. The sweep lights every numeral in ascending order, holds each one for a set dwell, and then goes back to the requested digit. Any request outside 0 to 9 blanks the tube at once. A blank request cancels any fade, roll or sweep in progress, and the next valid digit appears without a fade. The PWM period is a parameter in clocks. It should be at least 1 ms, so that a full fade lasts tens of milliseconds and the gas has time to de-ionize between switches.

Top module: `cathode_fade_seq`

## Requirements
- R1: While reset is held and after it is released, bcd_o is 15, onehot_o is all zero and busy_o is low until a valid digit is requested.
- R2: If the tube is blank, a valid digit on digit_i is shown on the next clock with no fade, and busy_o stays low.
- R3: onehot_o has bit n set exactly when bcd_o equals n, for n from 0 to 9. When bcd_o is the blank code 15, onehot_o is zero. At most one bit is ever set.
- R4: With mode_i = 0 (snap), a new valid digit is shown on the clock after it appears.
- R5: With mode_i = 1 or 3 (fade), a change of digit starts a fade and restarts the PWM period. The fade has 16 steps, k = 0 to 15, and each step lasts fade_len_i PWM periods, with 0 treated as 1. During step k the new digit is shown for the first k*PWM_CYC/16 clocks of each period and the old digit for the rest. After step 15 the new digit is shown fully and busy_o falls.
- R6: A change of digit during a fade restarts the fade at step 0. The restarted fade runs from the old digit, which is still held at full duty, to the latest request.
- R7: With mode_i = 2 (slot), a change of digit steps the shown numeral upward by one, wrapping from 9 to 0, once every fade_len_i PWM periods (0 treated as 1). It stops on the requested digit.
- R8: A pulse on sweep_i with a valid digit starts a sweep: busy_o rises and the PWM period restarts. Numerals 0 through 9 are then shown in order, each for dwell_i PWM periods (0 treated as 1). After that the current request is shown and busy_o falls. A change of digit during the sweep only updates the request. A pulse on sweep_i during a sweep is ignored.
- R9: A digit_i value from 10 to 15 blanks the tube on the next clock (bcd_o = 15, onehot_o = 0, busy_o low). It cancels any fade, roll or sweep, and it takes priority over sweep_i.
- R10: A request equal to the digit currently held at full duty ends any fade or roll at once. That digit is then shown with busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| digit_i | input | 4 | Requested BCD digit; 10 to 15 means blank |
| mode_i | input | 2 | Transition mode: 0 snap, 1 or 3 fade, 2 slot |
| fade_len_i | input | LEN_W | PWM periods per fade step or per slot numeral |
| dwell_i | input | DWELL_W | PWM periods per numeral during a sweep |
| sweep_i | input | 1 | Starts the cathode-exercise sweep |
| bcd_o | output | 4 | Selected numeral as BCD; 15 when blank |
| onehot_o | output | 10 | One-hot cathode select |
| busy_o | output | 1 | A fade, roll or sweep is in progress |

## Verification
The assertions assume that digit_i, mode_i, sweep_i and the length inputs change only between clock edges. They also assume that a valid digit_i held across two edges describes a settled request. The settled-output property therefore applies only when busy_o is low and the request did not change on the previous edge. The bench drives every input on the falling edge. It holds each request for many cycles, pulses sweep_i for a single cycle, and changes fade_len_i only while the block is idle.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FADE  = 2'd1,
    ST_SLOT  = 2'd2,
    ST_SWEEP = 2'd3
  } seq_st_e;

  localparam logic [3:0] BLANK_CODE = 4'hF;
  localparam logic [1:0] MODE_SNAP  = 2'd0;
  localparam logic [1:0] MODE_SLOT  = 2'd2;
  localparam int         FADE_STEPS = 16;
endpackage

// File: rtl/cfs_pwm_timer.sv
module cfs_pwm_timer #(
  parameter int PWM_CYC = 128000,
  parameter int POS_W   = $clog2(PWM_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [POS_W-1:0] pos_o,
  output logic             tick_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(PWM_CYC - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pos_q <= '0;
    else if (restart_i)   pos_q <= '0;
    else if (pos_q == LAST) pos_q <= '0;
    else                  pos_q <= pos_q + POS_W'(1);
  end

  assign pos_o  = pos_q;
  assign tick_o = (pos_q == LAST);
endmodule

// File: rtl/cfs_seq.sv
module cfs_seq
  import cfs_pkg::*;
#(
  parameter int PWM_CYC = 128000,
  parameter int POS_W   = $clog2(PWM_CYC),
  parameter int LEN_W   = 8,
  parameter int DWELL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         digit_i,
  input  logic [1:0]         mode_i,
  input  logic [LEN_W-1:0]   fade_len_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic               sweep_i,
  input  logic [POS_W-1:0]   pos_i,
  input  logic               tick_i,
  output logic               restart_o,
  output logic [3:0]         bcd_o,
  output logic               busy_o
);
  localparam int CNT_W = (LEN_W > DWELL_W) ? LEN_W : DWELL_W;
  localparam int SLICE = PWM_CYC / FADE_STEPS;

  seq_st_e      st_q;
  logic [3:0]   cur_q, to_q, req_q, step_q, idx_q;
  logic [CNT_W-1:0] cnt_q;

  logic blank_req, sweep_go, changed, take_now, start_tr, last_rep;
  logic [CNT_W:0] lim, cnt_nx;
  logic [3:0]   slot_nx;
  logic [31:0]  thr;

  assign blank_req = (digit_i > 4'd9);
  assign sweep_go  = !blank_req && sweep_i && (st_q != ST_SWEEP);
  assign changed   = !blank_req && !sweep_go && (digit_i != req_q) && (st_q != ST_SWEEP);
  assign take_now  = (cur_q == BLANK_CODE) || (digit_i == cur_q) || (mode_i == MODE_SNAP);
  assign start_tr  = changed && !take_now;
  assign restart_o = sweep_go || start_tr;

  // repeat limit per step; zero behaves as one
  assign lim     = (st_q == ST_SWEEP) ? (CNT_W+1)'(dwell_i) : (CNT_W+1)'(fade_len_i);
  assign cnt_nx  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign last_rep = (cnt_nx >= lim);
  assign slot_nx = (cur_q == 4'd9) ? 4'd0 : cur_q + 4'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= BLANK_CODE;
      to_q   <= '0;
      req_q  <= BLANK_CODE;
      step_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      req_q <= digit_i;
      if (blank_req) begin
        st_q  <= ST_IDLE;
        cur_q <= BLANK_CODE;
      end else if (sweep_go) begin
        st_q  <= ST_SWEEP;
        idx_q <= '0;
        cnt_q <= '0;
      end else if (changed) begin
        if (take_now) begin
          cur_q <= digit_i;
          st_q  <= ST_IDLE;
        end else begin
          st_q   <= (mode_i == MODE_SLOT) ? ST_SLOT : ST_FADE;
          to_q   <= digit_i;
          step_q <= '0;
          cnt_q  <= '0;
        end
      end else if (tick_i && st_q != ST_IDLE) begin
        if (!last_rep) begin
          cnt_q <= cnt_nx[CNT_W-1:0];
        end else begin
          cnt_q <= '0;
          unique case (st_q)
            ST_FADE: begin
              if (step_q == 4'(FADE_STEPS - 1)) begin
                cur_q <= to_q;
                st_q  <= ST_IDLE;
              end else begin
                step_q <= step_q + 4'd1;
              end
            end
            ST_SLOT: begin
              cur_q <= slot_nx;
              if (slot_nx == to_q) st_q <= ST_IDLE;
            end
            ST_SWEEP: begin
              if (idx_q == 4'd9) begin
                cur_q <= digit_i;
                st_q  <= ST_IDLE;
              end else begin
                idx_q <= idx_q + 4'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign thr = 32'(step_q) * 32'(SLICE);

  always_comb begin
    unique case (st_q)
      ST_FADE:  bcd_o = (32'(pos_i) < thr) ? to_q : cur_q;
      ST_SWEEP: bcd_o = idx_q;
      default:  bcd_o = cur_q;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/cfs_cathode_dec.sv
module cfs_cathode_dec #(
  parameter int N_CATH = 10
) (
  input  logic [3:0]        bcd_i,
  output logic [N_CATH-1:0] onehot_o
);
  for (genvar i = 0; i < N_CATH; i++) begin : g_dec
    assign onehot_o[i] = (bcd_i == 4'(i));
  end
endmodule

// File: rtl/cathode_fade_seq.sv
module cathode_fade_seq #(
  parameter int PWM_CYC = 128000,
  parameter int LEN_W   = 8,
  parameter int DWELL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         digit_i,
  input  logic [1:0]         mode_i,
  input  logic [LEN_W-1:0]   fade_len_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic               sweep_i,
  output logic [3:0]         bcd_o,
  output logic [9:0]         onehot_o,
  output logic               busy_o
);
  localparam int POS_W = $clog2(PWM_CYC);

  logic [POS_W-1:0] pos;
  logic             tick, restart;

  cfs_pwm_timer #(.PWM_CYC(PWM_CYC), .POS_W(POS_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .pos_o    (pos),
    .tick_o   (tick)
  );

  cfs_seq #(.PWM_CYC(PWM_CYC), .POS_W(POS_W), .LEN_W(LEN_W), .DWELL_W(DWELL_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .digit_i   (digit_i),
    .mode_i    (mode_i),
    .fade_len_i(fade_len_i),
    .dwell_i   (dwell_i),
    .sweep_i   (sweep_i),
    .pos_i     (pos),
    .tick_i    (tick),
    .restart_o (restart),
    .bcd_o     (bcd_o),
    .busy_o    (busy_o)
  );

  cfs_cathode_dec #(.N_CATH(10)) u_dec (
    .bcd_i   (bcd_o),
    .onehot_o(onehot_o)
  );
endmodule

// File: rtl/cathode_fade_seq_chk.sv
module cathode_fade_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] digit_i,
  input logic       sweep_i,
  input logic [3:0] bcd_o,
  input logic [9:0] onehot_o,
  input logic       busy_o
);
  AST_ONE_CATHODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(onehot_o)); // R3

  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcd_o <= 4'd9) || (bcd_o == 4'hF)); // R3

  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcd_o == 4'hF) |-> (onehot_o == '0)); // R3

  AST_BLANK_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_i > 4'd9) |=> (bcd_o == 4'hF && !busy_o)); // R9

  AST_SWEEP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_i && digit_i <= 4'd9) |=> busy_o); // R8

  AST_IDLE_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !busy_o && digit_i <= 4'd9 && $stable(digit_i)) |-> (bcd_o == digit_i)); // R2
endmodule

bind cathode_fade_seq cathode_fade_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .digit_i (digit_i),
  .sweep_i (sweep_i),
  .bcd_o   (bcd_o),
  .onehot_o(onehot_o),
  .busy_o  (busy_o)
);

// File: tb/tb_cathode_fade_seq.sv
`timescale 1ns/1ps
module tb_cathode_fade_seq;
  localparam int PWM   = 32;
  localparam int SLICE = PWM / 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] digit;
  logic [1:0] mode;
  logic [3:0] flen, dwell;
  logic       sweep;
  logic [3:0] bcd;
  logic [9:0] onehot;
  logic       busy;

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  // model state: 0 idle, 1 fade, 2 slot, 3 sweep
  int m_st, m_cur, m_to, m_req, m_step, m_cnt, m_idx, m_pos, m_lim;
  bit m_tick;

  always #4 clk = ~clk;

  cathode_fade_seq #(.PWM_CYC(PWM), .LEN_W(4), .DWELL_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .mode_i(mode),
    .fade_len_i(flen), .dwell_i(dwell), .sweep_i(sweep),
    .bcd_o(bcd), .onehot_o(onehot), .busy_o(busy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cur = 15; m_to = 0; m_req = 15; m_step = 0; m_cnt = 0; m_idx = 0; m_pos = 0;
    end else begin
      m_tick = (m_pos == PWM - 1);
      m_lim  = (m_st == 3) ? int'(dwell) : int'(flen);
      if (m_lim < 1) m_lim = 1;
      if (digit > 9) begin
        m_st = 0; m_cur = 15; m_pos = m_tick ? 0 : m_pos + 1;
      end else if (sweep && m_st != 3) begin
        m_st = 3; m_idx = 0; m_cnt = 0; m_pos = 0;
      end else if (int'(digit) != m_req && m_st != 3) begin
        if (m_cur == 15 || int'(digit) == m_cur || mode == 0) begin
          m_cur = digit; m_st = 0; m_pos = m_tick ? 0 : m_pos + 1;
        end else begin
          m_st = (mode == 2) ? 2 : 1; m_to = digit; m_step = 0; m_cnt = 0; m_pos = 0;
        end
      end else begin
        m_pos = m_tick ? 0 : m_pos + 1;
        if (m_tick && m_st != 0) begin
          if (m_cnt + 1 < m_lim) m_cnt++;
          else begin
            m_cnt = 0;
            if (m_st == 1) begin
              if (m_step == 15) begin m_cur = m_to; m_st = 0; end
              else m_step++;
            end else if (m_st == 2) begin
              m_cur = (m_cur + 1) % 10;
              if (m_cur == m_to) m_st = 0;
            end else begin
              if (m_idx == 9) begin m_cur = digit; m_st = 0; end
              else m_idx++;
            end
          end
        end
      end
      m_req = digit;
    end
  end

  function automatic int exp_bcd();
    if (m_st == 1) return (m_pos < m_step * SLICE) ? m_to : m_cur;
    if (m_st == 3) return m_idx;
    return m_cur;
  endfunction

  always @(negedge clk) begin
    int e;
    cyc++;
    if (rst_n) begin
      e = exp_bcd();
      chk(phase, int'(bcd), e);
      chk(phase, int'(busy), (m_st != 0) ? 1 : 0);
      chk("R3", int'(onehot), (e <= 9) ? (1 << e) : 0);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; digit = 4'd15; mode = 2'd0; sweep = 1'b0; flen = 4'd2; dwell = 4'd3;
    step(3);
    chk("R1", int'(bcd), 15); chk("R1", int'(onehot), 0); chk("R1", int'(busy), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1", int'(bcd), 15);

    phase = "R2"; digit = 4'd3; step(1);
    chk("R2", int'(bcd), 3); chk("R2", int'(busy), 0);

    phase = "R4"; digit = 4'd7; step(1);
    chk("R4", int'(bcd), 7);

    phase = "R5"; mode = 2'd1; digit = 4'd2; step(1);
    chk("R5", int'(busy), 1); chk("R5", int'(bcd), 7);
    step(1030);
    chk("R5", int'(bcd), 2); chk("R5", int'(busy), 0);

    phase = "R6"; digit = 4'd5; step(300);
    digit = 4'd8; step(1030);
    chk("R6", int'(bcd), 8); chk("R6", int'(busy), 0);

    phase = "R10"; digit = 4'd1; step(200);
    digit = 4'd8; step(1);
    chk("R10", int'(bcd), 8); chk("R10", int'(busy), 0);

    phase = "R5"; flen = 4'd0; mode = 2'd3; digit = 4'd4; step(16 * PWM + 5);
    chk("R5", int'(bcd), 4); chk("R5", int'(busy), 0);

    phase = "R7"; mode = 2'd2; flen = 4'd1; digit = 4'd2; step(1);
    chk("R7", int'(bcd), 4);
    step(PWM);
    chk("R7", int'(bcd), 5);
    step(8 * PWM);
    chk("R7", int'(bcd), 2); chk("R7", int'(busy), 0);

    phase = "R8"; mode = 2'd1; sweep = 1'b1; step(1);
    sweep = 1'b0;
    chk("R8", int'(busy), 1); chk("R8", int'(bcd), 0);
    step(40);
    sweep = 1'b1; step(1); sweep = 1'b0;
    digit = 4'd6; step(1000);
    chk("R8", int'(bcd), 6); chk("R8", int'(busy), 0);

    phase = "R9"; digit = 4'd9; step(100);
    digit = 4'd12; step(1);
    chk("R9", int'(bcd), 15); chk("R9", int'(busy), 0); chk("R9", int'(onehot), 0);
    sweep = 1'b1; step(1); sweep = 1'b0;
    chk("R9", int'(busy), 0);
    phase = "R2"; digit = 4'd5; step(1);
    chk("R2", int'(bcd), 5); chk("R2", int'(busy), 0);

    phase = "R9"; sweep = 1'b1; step(1); sweep = 1'b0;
    step(50);
    digit = 4'd10; step(1);
    chk("R9", int'(bcd), 15); chk("R9", int'(busy), 0);
    phase = "R2"; digit = 4'd0; step(1);
    chk("R2", int'(bcd), 0); chk("R3", int'(onehot), 1);
    step(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule